// File: doc/BRIEF.md
# Programmable-Threshold FIFO with Read Rewind

A single-clock first-in first-out buffer, 256 words of 36 bits by default, with one write port and one read port. Read data leaves through an output register that is loaded only when a read is accepted. Writes are dropped while the buffer is full, and reads are dropped while it is empty.

Five status outputs track the fill level: full, almost-full, half-full, almost-empty and empty. The almost-full and almost-empty margins sit in two offset registers. Each register is loaded at run time through its own load strobe and value bus, and each returns to a default of eight on reset. The four boundary flags have two different edges. A flag rises just after the rising clock edge of the access that brings the level into its region. It drops only after the falling edge that follows the access that takes the level out of that region. Half-full follows the level on the rising edge, in both directions.

An active-low rewind strobe sends the read pointer back to location 0 and leaves the write pointer where it is. This lets the block of words between location 0 and the write pointer be read again. The fill level and every flag are then derived from that block.

Top module: `pfifo_rt`

## Requirements
- R1: While `rst_n` is low, and after it is released, the buffer is empty: `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0, `half_full`=0, `rd_data`=0. Both offsets return to RST_OFS (default 8), even if they were reprogrammed before the reset.
- R2: Accepted reads return words in the order they were written. `rd_data` changes on the rising edge of an accepted read and holds its value in every other cycle.
- R3: A write while the level equals DEPTH is ignored. The level stays at DEPTH, and the stored words and their order are unchanged.
- R4: A read while the level is 0 is ignored. `rd_data` keeps its value and the buffer stays empty.
- R5: `full` (level = DEPTH) and `almost_full` rise right after the rising edge of the write that enters their region. They fall right after the falling edge that follows the read that leaves the region, and no earlier.
- R6: `empty` (level = 0) and `almost_empty` rise right after the rising edge of the read that enters their region. They fall right after the falling edge that follows the write that leaves the region, and no earlier.
- R7: `half_full` equals (level ≥ DEPTH/2+1) from the rising edge of each access, in both directions.
- R8: The almost-full region is DEPTH − level ≤ full-margin offset. The almost-empty region is level ≤ empty-margin offset. `af_ld`/`ae_ld` load `af_val`/`ae_val` on a rising edge, and any value from 0 to DEPTH−1 is accepted.
- R9: When a read and a write are both accepted in one cycle, the level is unchanged. At level DEPTH only the read is accepted. At level 0 only the write is accepted.
- R10: A rising edge with `rt_n` low puts the read pointer at location 0 and leaves the write pointer alone. It ignores any read or write in that cycle. It sets the level to the write pointer's location, or to DEPTH when the write pointer has wrapped back to location 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Registered read word |
| rt_n | input | 1 | Rewind strobe, active low |
| af_ld | input | 1 | Load the almost-full margin |
| af_val | input | OFS_W | New almost-full margin |
| ae_ld | input | 1 | Load the almost-empty margin |
| ae_val | input | OFS_W | New almost-empty margin |
| full | output | 1 | Level equals DEPTH |
| almost_full | output | 1 | Free space at or below the margin |
| half_full | output | 1 | Level at least DEPTH/2+1 |
| almost_empty | output | 1 | Level at or below the margin |
| empty | output | 1 | Level is 0 |

## Verification
The bench builds the block with DEPTH=16, WIDTH=8 and RST_OFS=3, so OFS_W is 4. At that size every fill level from 0 to 16 can be visited under every almost-full margin, each paired with a matching almost-empty margin. This brings both flag regions, the half-full boundary at 9, and the ignored write and read at each end within a few hundred cycles. The small depth also lets a rewind after a full wrap of the write pointer be tested directly.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;

  // Boundary flags that rise on the rising edge and fall on the falling edge.
  typedef struct packed {
    logic full;
    logic afull;
    logic aempty;
    logic empty;
  } edge_flags_t;

  // Level after one cycle of accepted pushes and pops.
  function automatic int unsigned next_fill(int unsigned cur, logic push, logic pop);
    return cur + (push ? 32'd1 : 32'd0) - (pop ? 32'd1 : 32'd0);
  endfunction

  // True when an amount lies inside a margin.
  function automatic logic within_margin(int unsigned amount, int unsigned margin);
    return amount <= margin;
  endfunction

  // Level after a rewind: the span from location 0 up to the write pointer.
  function automatic int unsigned rewind_fill(int unsigned wpos, logic lapped, int unsigned depth);
    return (wpos == 0 && lapped) ? depth : wpos;
  endfunction

  // Circular pointer increment.
  function automatic int unsigned step_ptr(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 32'd0 : p + 32'd1;
  endfunction

endpackage

// File: rtl/pfifo_store.sv
module pfifo_store #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 36,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_acc,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_acc,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] cells [DEPTH];
  logic [WIDTH-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_acc) cells[waddr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (rd_acc) rd_q <= cells[raddr];
  end

  assign rd_data = rd_q;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rd_acc |=> $stable(rd_q)); // R2

endmodule

// File: rtl/pfifo_ctrl.sv
module pfifo_ctrl
  import pfifo_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          rt_n,
  output logic          wr_acc,
  output logic          rd_acc,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] fill
);

  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] fill_q;
  logic          lapped_q;
  logic          rewind;

  assign rewind = !rt_n;
  assign wr_acc = !rewind && wr_en && (fill_q != CW'(DEPTH));
  assign rd_acc = !rewind && rd_en && (fill_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q   <= '0;
      rptr_q   <= '0;
      fill_q   <= '0;
      lapped_q <= 1'b0;
    end else if (rewind) begin
      rptr_q <= '0;
      fill_q <= CW'(rewind_fill(32'(wptr_q), lapped_q, DEPTH));
    end else begin
      if (wr_acc) begin
        wptr_q <= AW'(step_ptr(32'(wptr_q), DEPTH));
        if (wptr_q == AW'(DEPTH - 1)) lapped_q <= 1'b1;
      end
      if (rd_acc) rptr_q <= AW'(step_ptr(32'(rptr_q), DEPTH));
      fill_q <= CW'(next_fill(32'(fill_q), wr_acc, rd_acc));
    end
  end

  assign waddr = wptr_q;
  assign raddr = rptr_q;
  assign fill  = fill_q;

  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) (fill_q == CW'(DEPTH) && wr_en && !rd_en && rt_n) |=> $stable(wptr_q) && fill_q == CW'(DEPTH)); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (fill_q == '0 && rd_en && !wr_en && rt_n) |=> $stable(rptr_q) && fill_q == '0); // R4
  AST_BOTH_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) (rd_en && wr_en && rt_n && fill_q != '0 && fill_q != CW'(DEPTH)) |=> $stable(fill_q)); // R9
  AST_RT_REWIND:    assert property (@(posedge clk) disable iff (!rst_n) !rt_n |=> rptr_q == '0 && $stable(wptr_q)); // R10

endmodule

// File: rtl/pfifo_flags.sv
module pfifo_flags
  import pfifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int RST_OFS = 8,
  localparam int OW = $clog2(DEPTH),
  localparam int CW = OW + 1,
  localparam int unsigned DEPTH_U = 32'(DEPTH),
  localparam int unsigned HALF_MARK = 32'(DEPTH / 2 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] fill,
  input  logic          af_ld,
  input  logic [OW-1:0] af_val,
  input  logic          ae_ld,
  input  logic [OW-1:0] ae_val,
  output logic          full_o,
  output logic          afull_o,
  output logic          half_o,
  output logic          aempty_o,
  output logic          empty_o
);

  logic [OW-1:0] af_ofs_q, ae_ofs_q;
  edge_flags_t   now_c, lag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      af_ofs_q <= OW'(RST_OFS);
      ae_ofs_q <= OW'(RST_OFS);
    end else begin
      if (af_ld) af_ofs_q <= af_val;
      if (ae_ld) ae_ofs_q <= ae_val;
    end
  end

  // Region membership from the registered level: changes just after the rising edge.
  always_comb begin
    now_c.full   = (fill == CW'(DEPTH));
    now_c.afull  = within_margin(DEPTH_U - 32'(fill), 32'(af_ofs_q));
    now_c.aempty = within_margin(32'(fill), 32'(ae_ofs_q));
    now_c.empty  = (fill == '0);
  end

  // Falling-edge copy keeps a flag up until the half cycle after its region is left.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) lag_q <= '0;
    else        lag_q <= now_c;
  end

  assign full_o   = now_c.full   | lag_q.full;
  assign afull_o  = now_c.afull  | lag_q.afull;
  assign aempty_o = now_c.aempty | lag_q.aempty;
  assign empty_o  = now_c.empty  | lag_q.empty;
  assign half_o   = 32'(fill) >= HALF_MARK;

  AST_FULL_IN_AFULL:  assert property (@(posedge clk) disable iff (!rst_n) full_o |-> afull_o); // R5
  AST_EMPTY_IN_AEMPTY: assert property (@(posedge clk) disable iff (!rst_n) empty_o |-> aempty_o); // R6
  AST_HALF_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) half_o |-> !empty_o || lag_q.empty); // R7

endmodule

// File: rtl/pfifo_rt.sv
module pfifo_rt #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 36,
  parameter int RST_OFS = 8,
  localparam int OFS_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic             rt_n,
  input  logic             af_ld,
  input  logic [OFS_W-1:0] af_val,
  input  logic             ae_ld,
  input  logic [OFS_W-1:0] ae_val,
  output logic             full,
  output logic             almost_full,
  output logic             half_full,
  output logic             almost_empty,
  output logic             empty
);

  localparam int AW = OFS_W;
  localparam int CW = AW + 1;

  logic          wr_acc, rd_acc;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] fill;

  pfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rt_n(rt_n),
    .wr_acc(wr_acc), .rd_acc(rd_acc), .waddr(waddr), .raddr(raddr), .fill(fill)
  );

  pfifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .waddr(waddr), .wr_data(wr_data),
    .rd_acc(rd_acc), .raddr(raddr), .rd_data(rd_data)
  );

  pfifo_flags #(.DEPTH(DEPTH), .RST_OFS(RST_OFS)) u_flags (
    .clk(clk), .rst_n(rst_n), .fill(fill),
    .af_ld(af_ld), .af_val(af_val), .ae_ld(ae_ld), .ae_val(ae_val),
    .full_o(full), .afull_o(almost_full), .half_o(half_full),
    .aempty_o(almost_empty), .empty_o(empty)
  );

endmodule

// File: tb/pfifo_rt_bench.sv
module pfifo_rt_bench;

  localparam int D  = 16;
  localparam int W  = 8;
  localparam int RO = 3;
  localparam int OW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, rt_n = 1'b1, af_ld = 1'b0, ae_ld = 1'b0;
  logic [W-1:0]  wr_data = '0;
  logic [OW-1:0] af_val = '0, ae_val = '0;
  logic [W-1:0]  rd_data;
  logic full, almost_full, half_full, almost_empty, empty;

  pfifo_rt #(.DEPTH(D), .WIDTH(W), .RST_OFS(RO)) u_pfifo_rt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rt_n(rt_n), .af_ld(af_ld), .af_val(af_val),
    .ae_ld(ae_ld), .ae_val(ae_val), .full(full), .almost_full(almost_full),
    .half_full(half_full), .almost_empty(almost_empty), .empty(empty)
  );

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0;

  // Reference model
  logic [W-1:0] mm [D];
  int mrp = 0, mwp = 0, mcnt = 0, maf = RO, mae = RO, seq = 0;
  bit mwrap = 0;
  logic [W-1:0] exp_rd = '0;

  function automatic bit c_full(int c);          return c == D;       endfunction
  function automatic bit c_af(int c, int o);     return c + o >= D;   endfunction
  function automatic bit c_ae(int c, int o);     return c <= o;       endfunction
  function automatic bit c_em(int c);            return c == 0;       endfunction
  function automatic bit c_hf(int c);            return 2 * c > D;    endfunction

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; rd_en = 1'b0; rt_n = 1'b1; af_ld = 1'b0; ae_ld = 1'b0;
  endtask

  // Called at 5 ns after a rising edge; returns at the same phase one cycle later.
  task automatic step(string tag, bit w, bit r, bit rt, bit afl, int afv, bit ael, int aev);
    bit pf_f, pf_af, pf_ae, pf_e, wa, ra;
    logic [W-1:0] wd;
    wd = W'(seq * 37 + 11);
    wr_en = w; rd_en = r; rt_n = !rt; wr_data = wd;
    af_ld = afl; af_val = OW'(afv); ae_ld = ael; ae_val = OW'(aev);
    pf_f = c_full(mcnt); pf_af = c_af(mcnt, maf); pf_ae = c_ae(mcnt, mae); pf_e = c_em(mcnt);
    @(posedge clk);
    if (afl) maf = afv;
    if (ael) mae = aev;
    if (rt) begin
      mrp = 0;
      mcnt = (mwp == 0 && mwrap) ? D : mwp;
    end else begin
      wa = w && (mcnt != D);
      ra = r && (mcnt != 0);
      if (ra) begin exp_rd = mm[mrp]; mrp = (mrp + 1) % D; end
      if (wa) begin
        mm[mwp] = wd; seq++;
        if (mwp == D - 1) mwrap = 1;
        mwp = (mwp + 1) % D;
      end
      mcnt = mcnt + int'(wa) - int'(ra);
    end
    #2;
    chk("R5", {"full after rise ", tag},  int'(full),         int'(c_full(mcnt) | pf_f));
    chk("R5", {"afull after rise ", tag}, int'(almost_full),  int'(c_af(mcnt, maf) | pf_af));
    chk("R6", {"aempty after rise ", tag}, int'(almost_empty), int'(c_ae(mcnt, mae) | pf_ae));
    chk("R6", {"empty after rise ", tag}, int'(empty),        int'(c_em(mcnt) | pf_e));
    chk("R7", {"half_full ", tag},        int'(half_full),    int'(c_hf(mcnt)));
    chk(tag, "rd_data", int'(rd_data), int'(exp_rd));
    idle_inputs();
    #3;
    chk("R5", {"full after fall ", tag},  int'(full),         int'(c_full(mcnt)));
    chk("R8", {"afull after fall ", tag}, int'(almost_full),  int'(c_af(mcnt, maf)));
    chk("R8", {"aempty after fall ", tag}, int'(almost_empty), int'(c_ae(mcnt, mae)));
    chk("R6", {"empty after fall ", tag}, int'(empty),        int'(c_em(mcnt)));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle_inputs();
    @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1", "empty in reset",  int'(empty), 1);
    chk("R1", "aempty in reset", int'(almost_empty), 1);
    chk("R1", "full in reset",   int'(full), 0);
    chk("R1", "afull in reset",  int'(almost_full), 0);
    chk("R1", "half in reset",   int'(half_full), 0);
    chk("R1", "rd_data in reset", int'(rd_data), 0);
    @(posedge clk);
    #5;
    rst_n = 1'b1;
    mrp = 0; mwp = 0; mcnt = 0; mwrap = 0; maf = RO; mae = RO; exp_rd = '0;
    @(posedge clk);
    #5;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    nfail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    do_reset();

    // R8 sweep: every almost-full margin with a complementary almost-empty margin.
    for (int o = 0; o < D; o++) begin
      step("R8", 0, 0, 0, 1, o, 1, D - 1 - o);
      for (int k = 0; k <= D; k++) begin
        string t;
        t = (k == D) ? "R3" : "R5";
        step(t, 1, 0, 0, 0, 0, 0, 0);
      end
      for (int k = 0; k <= D; k++) begin
        string t;
        t = (k == D) ? "R4" : "R2";
        step(t, 0, 1, 0, 0, 0, 0, 0);
      end
    end

    // R9: simultaneous accesses in the middle and at both ends.
    step("R8", 0, 0, 0, 1, RO, 1, RO);
    for (int k = 0; k < 8; k++)  step("R2", 1, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 10; k++) step("R9", 1, 1, 0, 0, 0, 0, 0);
    for (int k = 0; k < 8; k++)  step("R2", 0, 1, 0, 0, 0, 0, 0);
    step("R9", 1, 1, 0, 0, 0, 0, 0);
    step("R2", 0, 1, 0, 0, 0, 0, 0);
    for (int k = 0; k < D; k++)  step("R5", 1, 0, 0, 0, 0, 0, 0);
    step("R9", 1, 1, 0, 0, 0, 0, 0);
    step("R5", 1, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < D; k++)  step("R2", 0, 1, 0, 0, 0, 0, 0);

    // R1: reprogrammed margins return to default on reset.
    step("R8", 0, 0, 0, 1, 10, 1, 10);
    do_reset();
    for (int k = 0; k < 5; k++)  step("R1", 1, 0, 0, 0, 0, 0, 0);

    // R10: rewind after a short block, then after a full wrap of the write pointer.
    for (int k = 0; k < 5; k++)  step("R2", 0, 1, 0, 0, 0, 0, 0);
    step("R10", 0, 0, 1, 0, 0, 0, 0);
    for (int k = 0; k < 5; k++)  step("R10", 0, 1, 0, 0, 0, 0, 0);
    step("R4", 0, 1, 0, 0, 0, 0, 0);
    for (int k = 0; k < 11; k++) step("R5", 1, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++)  step("R2", 0, 1, 0, 0, 0, 0, 0);
    step("R10", 1, 1, 1, 0, 0, 0, 0);
    for (int k = 0; k < D; k++)  step("R10", 0, 1, 0, 0, 0, 0, 0);
    step("R4", 0, 1, 0, 0, 0, 0, 0);

    finish_run();
  end

endmodule